// File: doc/BRIEF.md
# Floating-Point Load Destination Renamer

This block gives new physical names to floating-point registers in an in-order issue front end, but only for the destination of a floating-point load. Adds, multiplies and other arithmetic operations read their source operands through the map table and never change it. Three structures hold the state. A map table gives the current physical register for each architectural register. A free list holds the unallocated physical registers in FIFO order. A pending return queue holds each displaced physical register, together with the tag of the load that displaced it, until that load completes.

In each cycle the front end may present one load for renaming, together with its destination and an instruction tag. It may also look up any number of source operands, set by a parameter. The sources are translated against the table as it stands before that cycle's update. When an instruction completes, it reports its tag on the completion port. It can also report the physical register it wrote, which marks that register's value as available. When the tag matches the load at the head of the pending queue, the head entry is released and its physical register goes to the back of the free list.

Top module: `fp_load_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and every physical register reads as ready. `ren_ready_o` is 1, and the allocation order of the free list is 32, 33, …, 39 (defaults: 32 architectural registers, 40 physical registers).
- R2: An accepted rename (`ren_valid_i` and `ren_ready_o` both 1) makes the destination map, from the next cycle on, to the register shown on `ren_phys_o` in the accepting cycle. That register's ready bit reads 0 from then on, until it is written.
- R3: A source lookup in the same cycle as an accepted rename of the same architectural register returns the mapping as it was before the rename.
- R4: `ren_ready_o` is 0 whenever the free list is empty or the pending queue is full. A request presented while it is 0 changes no mapping.
- R5: Physical registers are handed out in FIFO order. A register released from the pending queue is handed out only after every register that was already on the free list.
- R6: A completion whose tag differs from the tag at the head of the pending queue, or that arrives while the queue is empty, frees no register.
- R7: A completion with `cmp_wr_i` = 1 sets the ready bit of `cmp_phys_i`, and source lookups return the new bit from the next cycle on. An allocation of the same register in the same cycle takes priority and clears the bit.
- R8: A rename and a head release in the same cycle both take effect: one register leaves the front of the free list and the released register joins its back.
- R9: A completion releases at most one queue entry, even when the next entry carries the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | A load requests renaming |
| ren_arch_i | input | 5 | Destination architectural register of the load |
| ren_tag_i | input | 4 | Instruction tag of the load |
| ren_ready_o | output | 1 | A rename can be accepted this cycle |
| ren_phys_o | output | 6 | Physical register that the next accepted rename receives |
| src_arch_i | input | 2x5 | Architectural source registers to look up |
| src_phys_o | output | 2x6 | Current physical register for each source |
| src_rdy_o | output | 2 | Ready bit of each looked-up physical register |
| cmp_valid_i | input | 1 | An instruction completes |
| cmp_tag_i | input | 4 | Tag of the completing instruction |
| cmp_wr_i | input | 1 | The completing instruction wrote a physical register |
| cmp_phys_i | input | 6 | Physical register written by the completing instruction |

## Verification
Two operations can fall in the same cycle: an allocation, which pops the free list and pushes the pending queue, and a head release, which pops the pending queue and pushes the free list. The random stimulus points the completion tag at the current head half of the time while renames keep arriving. A directed step also issues a rename and a matching completion together. Each such collision is judged by the register `ren_phys_o` offers afterwards and by `ren_ready_o`, both compared with a FIFO model held in the bench. A separate directed case shows that a completion write and an allocation that land on the same register leave its ready bit cleared.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned NUM_ARCH_DEF = 32;
  localparam int unsigned NUM_PHYS_DEF = 40;
  localparam int unsigned TAG_W_DEF    = 4;
  localparam int unsigned NUM_SRC_DEF  = 2;

  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/rn_fifo.sv
module rn_fifo #(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned WIDTH     = 6,
  parameter bit          INIT_FULL = 1'b0,
  parameter int unsigned INIT_BASE = 0,
  localparam int unsigned PTRW     = rn_pkg::ptr_w(DEPTH),
  localparam int unsigned CNTW     = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNTW-1:0]  cnt_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTRW-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNTW-1:0]  cnt_q;

  function automatic logic [PTRW-1:0] nxt(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++)
        mem_q[i] <= INIT_FULL ? WIDTH'(INIT_BASE + i) : '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= INIT_FULL ? CNTW'(DEPTH) : '0;
    end else begin
      if (push_i) begin
        mem_q[wr_ptr_q] <= push_data_i;
        wr_ptr_q        <= nxt(wr_ptr_q);
      end
      if (pop_i) rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned PW       = 6,
  localparam int unsigned AW      = $clog2(NUM_ARCH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [AW-1:0]               wr_arch_i,
  input  logic [PW-1:0]               wr_phys_i,
  output logic [PW-1:0]               old_phys_o,
  input  logic [NUM_SRC-1:0][AW-1:0]  rd_arch_i,
  output logic [NUM_SRC-1:0][PW-1:0]  rd_phys_o
);
  logic [PW-1:0] map_q [NUM_ARCH];

  assign old_phys_o = map_q[wr_arch_i];

  // reads see the table before this cycle's write
  for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_rd
    assign rd_phys_o[s] = map_q[rd_arch_i[s]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_ARCH); i++) map_q[i] <= PW'(i);
    end else if (wr_en_i) begin
      map_q[wr_arch_i] <= wr_phys_i;
    end
  end
endmodule

// File: rtl/rn_ready_vec.sv
module rn_ready_vec #(
  parameter int unsigned NUM_PHYS = 40,
  parameter int unsigned NUM_SRC  = 2,
  localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        set_i,
  input  logic [PW-1:0]               set_idx_i,
  input  logic                        clr_i,
  input  logic [PW-1:0]               clr_idx_i,
  input  logic [NUM_SRC-1:0][PW-1:0]  rd_idx_i,
  output logic [NUM_SRC-1:0]          rd_rdy_o,
  output logic [NUM_PHYS-1:0]         rdy_o
);
  logic [NUM_PHYS-1:0] rdy_q;

  assign rdy_o = rdy_q;

  for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_rd
    assign rd_rdy_o[s] = rdy_q[rd_idx_i[s]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= '1;
    end else begin
      if (set_i) rdy_q[set_idx_i] <= 1'b1;
      // allocation wins over a same-cycle write
      if (clr_i) rdy_q[clr_idx_i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_load_renamer.sv
module fp_load_renamer #(
  parameter int unsigned NUM_ARCH  = rn_pkg::NUM_ARCH_DEF,
  parameter int unsigned NUM_PHYS  = rn_pkg::NUM_PHYS_DEF,
  parameter int unsigned TAG_W     = rn_pkg::TAG_W_DEF,
  parameter int unsigned NUM_SRC   = rn_pkg::NUM_SRC_DEF,
  parameter int unsigned PRQ_DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int unsigned AW       = $clog2(NUM_ARCH),
  localparam int unsigned PW       = $clog2(NUM_PHYS),
  localparam int unsigned FREE_N   = NUM_PHYS - NUM_ARCH,
  localparam int unsigned FCW      = $clog2(FREE_N + 1),
  localparam int unsigned QCW      = $clog2(PRQ_DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ren_valid_i,
  input  logic [AW-1:0]               ren_arch_i,
  input  logic [TAG_W-1:0]            ren_tag_i,
  output logic                        ren_ready_o,
  output logic [PW-1:0]               ren_phys_o,
  input  logic [NUM_SRC-1:0][AW-1:0]  src_arch_i,
  output logic [NUM_SRC-1:0][PW-1:0]  src_phys_o,
  output logic [NUM_SRC-1:0]          src_rdy_o,
  input  logic                        cmp_valid_i,
  input  logic [TAG_W-1:0]            cmp_tag_i,
  input  logic                        cmp_wr_i,
  input  logic [PW-1:0]               cmp_phys_i
);
  logic                ren_fire, ret_pop;
  logic [PW-1:0]       free_head, old_phys;
  logic                free_empty, free_full;
  logic [FCW-1:0]      free_cnt;
  logic [TAG_W+PW-1:0] prq_head;
  logic                prq_empty, prq_full;
  logic [QCW-1:0]      prq_cnt;
  logic [NUM_PHYS-1:0] rdy_vec;

  assign ren_ready_o = !free_empty && !prq_full;
  assign ren_fire    = ren_valid_i && ren_ready_o;
  assign ren_phys_o  = free_head;
  assign ret_pop     = cmp_valid_i && !prq_empty && (prq_head[TAG_W+PW-1:PW] == cmp_tag_i);

  rn_fifo #(
    .DEPTH(FREE_N), .WIDTH(PW), .INIT_FULL(1'b1), .INIT_BASE(NUM_ARCH)
  ) u_free (
    .clk_i, .rst_ni,
    .push_i(ret_pop), .push_data_i(prq_head[PW-1:0]),
    .pop_i(ren_fire), .head_o(free_head),
    .empty_o(free_empty), .full_o(free_full), .cnt_o(free_cnt)
  );

  rn_fifo #(
    .DEPTH(PRQ_DEPTH), .WIDTH(TAG_W + PW), .INIT_FULL(1'b0), .INIT_BASE(0)
  ) u_prq (
    .clk_i, .rst_ni,
    .push_i(ren_fire), .push_data_i({ren_tag_i, old_phys}),
    .pop_i(ret_pop), .head_o(prq_head),
    .empty_o(prq_empty), .full_o(prq_full), .cnt_o(prq_cnt)
  );

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_SRC(NUM_SRC), .PW(PW)) u_map (
    .clk_i, .rst_ni,
    .wr_en_i(ren_fire), .wr_arch_i(ren_arch_i), .wr_phys_i(free_head),
    .old_phys_o(old_phys),
    .rd_arch_i(src_arch_i), .rd_phys_o(src_phys_o)
  );

  rn_ready_vec #(.NUM_PHYS(NUM_PHYS), .NUM_SRC(NUM_SRC)) u_rdy (
    .clk_i, .rst_ni,
    .set_i(cmp_valid_i && cmp_wr_i), .set_idx_i(cmp_phys_i),
    .clr_i(ren_fire), .clr_idx_i(free_head),
    .rd_idx_i(src_phys_o), .rd_rdy_o(src_rdy_o),
    .rdy_o(rdy_vec)
  );
endmodule

// File: rtl/fp_load_renamer_chk.sv
module fp_load_renamer_chk #(
  parameter int unsigned NUM_PHYS = 40,
  parameter int unsigned FREE_N   = 8,
  parameter int unsigned FCW      = 4,
  parameter int unsigned QCW      = 4,
  localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ren_valid_i,
  input logic                ren_ready_o,
  input logic [PW-1:0]       ren_phys_o,
  input logic [FCW-1:0]      free_cnt,
  input logic                free_full,
  input logic [QCW-1:0]      prq_cnt,
  input logic                ret_pop,
  input logic [NUM_PHYS-1:0] rdy_vec
);
  AST_STALL_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt == '0) |-> !ren_ready_o); // R4
  AST_NAMES_CONSERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(free_cnt) + int'(prq_cnt)) == int'(FREE_N)); // R8
  AST_ALLOC_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_ready_o) |=> !rdy_vec[$past(ren_phys_o)]); // R2
  AST_ALLOC_TAKES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_ready_o && !ret_pop) |=> (int'(free_cnt) == int'($past(free_cnt)) - 1)); // R2
  AST_RELEASE_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_pop |-> (prq_cnt != '0)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_full |-> !ret_pop); // R5
endmodule

bind fp_load_renamer fp_load_renamer_chk #(
  .NUM_PHYS(NUM_PHYS), .FREE_N(FREE_N), .FCW(FCW), .QCW(QCW)
) u_chk (
  .clk_i, .rst_ni, .ren_valid_i, .ren_ready_o, .ren_phys_o,
  .free_cnt, .free_full, .prq_cnt, .ret_pop, .rdy_vec
);

// File: tb/fp_load_renamer_tb.sv
`timescale 1ns/1ps
module fp_load_renamer_tb;
  localparam int NA = 32, NP = 40, TW = 4, NS = 2, QD = 8;
  localparam int AW = 5, PW = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ren_valid_i = 1'b0, ren_ready_o;
  logic [AW-1:0] ren_arch_i = '0;
  logic [TW-1:0] ren_tag_i = '0;
  logic [PW-1:0] ren_phys_o;
  logic [NS-1:0][AW-1:0] src_arch_i = '0;
  logic [NS-1:0][PW-1:0] src_phys_o;
  logic [NS-1:0] src_rdy_o;
  logic cmp_valid_i = 1'b0, cmp_wr_i = 1'b0;
  logic [TW-1:0] cmp_tag_i = '0;
  logic [PW-1:0] cmp_phys_i = '0;

  fp_load_renamer u_dut (.*);

  always #2 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  int map_m [NA];
  bit rdy_m [NP];
  int free_q [$];
  int prq_tag [$];
  int prq_phys [$];
  bit last_both = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) rdy_m[i] = 1'b1;
    free_q.delete(); prq_tag.delete(); prq_phys.delete();
    for (int i = NA; i < NP; i++) free_q.push_back(i);
    last_both = 0;
  endfunction

  function automatic bit exp_ready();
    return free_q.size() != 0 && prq_tag.size() < QD;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; ren_valid_i = 0; cmp_valid_i = 0; cmp_wr_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
  endtask

  task automatic step(input bit rv, input int ra, input int rt,
                      input bit cv, input int ct, input bit cw, input int cp,
                      input int s0, input int s1);
    bit er, acc, ret;
    int nw;
    @(negedge clk_i);
    ren_valid_i = rv; ren_arch_i = AW'(ra); ren_tag_i = TW'(rt);
    cmp_valid_i = cv; cmp_tag_i = TW'(ct); cmp_wr_i = cw; cmp_phys_i = PW'(cp);
    src_arch_i[0] = AW'(s0); src_arch_i[1] = AW'(s1);
    #1;
    er = exp_ready();
    chk(ren_ready_o == er, last_both ? "R8 ready" : "R4 ready", ren_ready_o, er);
    if (er) chk(int'(ren_phys_o) == free_q[0], last_both ? "R8 alloc" : "R5 alloc order",
                ren_phys_o, free_q[0]);
    for (int k = 0; k < NS; k++) begin
      int sa = (k == 0) ? s0 : s1;
      chk(int'(src_phys_o[k]) == map_m[sa], (rv && er && sa == ra) ? "R3 lookup" : "R2 lookup",
          src_phys_o[k], map_m[sa]);
      chk(src_rdy_o[k] == rdy_m[map_m[sa]], "R7 ready bit", src_rdy_o[k], rdy_m[map_m[sa]]);
    end
    @(posedge clk_i);
    acc = rv && er;
    ret = cv && prq_tag.size() != 0 && prq_tag[0] == ct;
    if (cv && cw) rdy_m[cp] = 1'b1;
    if (acc) begin
      nw = free_q.pop_front();
      prq_tag.push_back(rt); prq_phys.push_back(map_m[ra]);
      map_m[ra] = nw;
      rdy_m[nw] = 1'b0;
    end
    if (ret) begin
      free_q.push_back(prq_phys[0]);
      void'(prq_tag.pop_front()); void'(prq_phys.pop_front());
    end
    last_both = acc && ret;
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int i = 0; i < NA; i++) begin
      src_arch_i[0] = AW'(i); src_arch_i[1] = AW'((i + 7) % NA);
      #1;
      chk(int'(src_phys_o[0]) == i, "R1 map", src_phys_o[0], i);
      chk(src_rdy_o[0] == 1'b1, "R1 rdy", src_rdy_o[0], 1);
    end
    chk(ren_ready_o == 1'b1, "R1 ready", ren_ready_o, 1);
    chk(int'(ren_phys_o) == NA, "R1 first free", ren_phys_o, NA);

    // fill: same-register source and destination (R3), then exhaust the free list
    for (int i = 0; i < 8; i++) step(1, i, i + 1, 0, 0, 0, 0, i, 0);
    step(1, 3, 9, 0, 0, 0, 0, 3, 4);             // stalled request: R4
    step(0, 0, 0, 1, 9, 0, 0, 3, 0);             // non-matching tag
    step(0, 0, 0, 0, 0, 0, 0, 3, 0);
    chk(ren_ready_o == 1'b0, "R6 no release", ren_ready_o, 0);
    step(0, 0, 0, 1, 1, 1, 32, 0, 1);            // release head, write 32
    step(1, 10, 2, 1, 2, 0, 0, 10, 0);           // rename + release: R8
    step(0, 0, 0, 0, 0, 0, 0, 10, 1);
    // write and allocate the same register together: allocation wins (R7)
    step(1, 11, 3, 1, 3, 1, int'(ren_phys_o), 11, 0);
    step(0, 0, 0, 0, 0, 0, 0, 11, 0);
    chk(src_rdy_o[0] == 1'b0, "R7 alloc wins", src_rdy_o[0], 0);

    // R9: two head entries share a tag
    do_reset();
    for (int i = 0; i < 8; i++) step(1, i + 4, (i < 2) ? 7 : i + 8, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 7, 0, 0, 4, 5);
    step(1, 20, 1, 0, 0, 0, 0, 20, 4);
    step(0, 0, 0, 0, 0, 0, 0, 20, 5);
    chk(ren_ready_o == 1'b0, "R9 single release", ren_ready_o, 0);

    // constrained random
    do_reset();
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 3000; n++) begin
      int ra = $urandom_range(NA - 1);
      int ht = (prq_tag.size() != 0) ? prq_tag[0] : 0;
      bit aim = $urandom_range(1);
      int s0 = ($urandom_range(3) == 0) ? ra : $urandom_range(NA - 1);
      step($urandom_range(3) != 0, ra, $urandom_range(15),
           $urandom_range(1), aim ? ht : $urandom_range(15),
           $urandom_range(1), $urandom_range(NP - 1),
           s0, $urandom_range(NA - 1));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule